// File: doc/BRIEF.md
# Chip-Select Region Decoder with Error Detection

The block takes a system-side access address and picks which of eight external chip-select regions it belongs to. Each region has a programmable base, a mask and an enable bit. A region matches when the upper address bits, ANDed with the region mask, equal the region base ANDed with the same mask. A zero bit in the mask therefore means "don't care" for that address bit. When exactly one enabled region matches, the block registers a one-hot select and a grant so the access is forwarded to the external interface.

Some accesses hit no enabled region, and some hit two or more enabled regions at once. Neither case is resolved by priority. No chip-select is driven, and the block produces a one-cycle error pulse. A sticky error flag is also set, and it captures the address of the first faulting access until software clears it. Every request is acknowledged one cycle later, whether it succeeded or failed, so the requester never stalls.

After reset, only region 0 is enabled. Its base and mask are zero, so it covers the whole address space. Regions 1 to 7 start disabled. A single-entry write port loads the settings of one region per cycle.

Top module: `cs_region_decoder`

## Requirements
- R1: After reset, cs_sel, grant, req_ack and err_pulse are 0 and err_sticky is 0. Only region 0 is enabled, with base 0 and mask 0, so any request made before any configuration write gives cs_sel = 1 (bit 0) and grant = 1.
- R2: A request whose address matches exactly one enabled region gives, in the cycle after the request edge, cs_sel with only that region's bit (bit i for region i) set and grant = 1. cs_sel is always one-hot or zero.
- R3: A request that matches no enabled region gives cs_sel = 0 and grant = 0, with err_pulse = 1 for one cycle. This covers a match with a disabled region and an address outside every region.
- R4: A request that matches two or more enabled regions gives cs_sel = 0, grant = 0 and err_pulse = 1. No matching chip-select is asserted.
- R5: Every request is answered with req_ack = 1 in the next cycle, including requests that end in an error.
- R6: In a cycle after an edge with req_valid = 0, cs_sel, grant, req_ack and err_pulse are all 0.
- R7: An error while err_sticky is 0 sets err_sticky and loads err_addr with the full faulting address, in the same cycle as err_pulse. Later errors leave err_addr unchanged while err_sticky stays set.
- R8: err_clr = 1 at an edge clears err_sticky. If an error occurs at the same edge, err_sticky stays 1 and err_addr takes the new faulting address.
- R9: cfg_wr = 1 at an edge loads cfg_base, cfg_mask and cfg_enable into region cfg_idx. A request at the next edge is decoded with the new settings.
- R10: The match test for region i is ((addr[ADDR_W-1 -: MATCH_W] XOR base_i) AND mask_i) == 0 with enable_i = 1. Address bits below the top MATCH_W bits never affect the decode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_addr | input | ADDR_W | Access address |
| cfg_wr | input | 1 | Write one region's settings |
| cfg_idx | input | clog2(NUM_REGIONS) | Region written by cfg_wr |
| cfg_base | input | MATCH_W | New base for the region |
| cfg_mask | input | MATCH_W | New mask for the region |
| cfg_enable | input | 1 | New enable bit for the region |
| err_clr | input | 1 | Write-one-to-clear for the sticky error |
| cs_sel | output | NUM_REGIONS | Registered one-hot chip-select |
| grant | output | 1 | Access forwarded to the external interface |
| req_ack | output | 1 | Request answered (success or error) |
| err_pulse | output | 1 | One-cycle access error |
| err_sticky | output | 1 | Sticky access-error flag |
| err_addr | output | ADDR_W | Address of the first error since the last clear |

## Verification
Every decode result is visible at the ports one cycle after its request. Because of that, a wrong stored base, mask or enable bit shows up within one cycle as a wrong select bit, a missing grant or a spurious error pulse. The bench reaches such faults by sweeping every address of a small configuration. A corrupted sticky flag or captured address is visible at once on err_sticky and err_addr. It stays visible until the next clear, so a single check after each request exposes it.

// File: rtl/cs_dec_pkg.sv
package cs_dec_pkg;

   // Result of decoding one request, held for one cycle.
   typedef enum logic [1:0] {
      OUTC_IDLE  = 2'd0,
      OUTC_GRANT = 2'd1,
      OUTC_MISS  = 2'd2,
      OUTC_CLASH = 2'd3
   } outcome_e;

endpackage

// File: rtl/cs_cfg_bank.sv
module cs_cfg_bank #(
   parameter int NUM_REGIONS = 8,
   parameter int MATCH_W     = 8,
   localparam int IDX_W      = $clog2(NUM_REGIONS)
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic                                  wr_en,
   input  logic [IDX_W-1:0]                      wr_idx,
   input  logic [MATCH_W-1:0]                    wr_base,
   input  logic [MATCH_W-1:0]                    wr_mask,
   input  logic                                  wr_enable,
   output logic [NUM_REGIONS-1:0][MATCH_W-1:0]   base_q,
   output logic [NUM_REGIONS-1:0][MATCH_W-1:0]   mask_q,
   output logic [NUM_REGIONS-1:0]                en_q
);

   // Reset: region 0 covers everything, the others are off.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int r = 0; r < NUM_REGIONS; r++) begin
            base_q[r] <= '0;
            mask_q[r] <= '0;
            en_q[r]   <= (r == 0);
         end
      end else if (wr_en) begin
         for (int r = 0; r < NUM_REGIONS; r++) begin
            if (wr_idx == IDX_W'(r)) begin
               base_q[r] <= wr_base;
               mask_q[r] <= wr_mask;
               en_q[r]   <= wr_enable;
            end
         end
      end
   end

   // R9: a write lands in the addressed region.
   a_r9_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (en_q[$past(wr_idx)] == $past(wr_enable))
             && (base_q[$past(wr_idx)] == $past(wr_base))
             && (mask_q[$past(wr_idx)] == $past(wr_mask)));

endmodule

// File: rtl/cs_region_match.sv
module cs_region_match #(
   parameter int MATCH_W = 8
) (
   input  logic [MATCH_W-1:0] tag,
   input  logic [MATCH_W-1:0] base,
   input  logic [MATCH_W-1:0] mask,
   input  logic               enable,
   output logic               hit
);

   // R10: masked comparison; a zero mask bit is don't-care.
   assign hit = enable && (((tag ^ base) & mask) == '0);

endmodule

// File: rtl/cs_err_track.sv
module cs_err_track #(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              err_in,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic              clr,
   output logic              sticky_q,
   output logic [ADDR_W-1:0] addr_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sticky_q <= 1'b0;
         addr_q   <= '0;
      end else begin
         if (clr) sticky_q <= 1'b0;
         if (err_in && (clr || !sticky_q)) begin
            sticky_q <= 1'b1;
            addr_q   <= addr_in;
         end
      end
   end

   // R7: the first error is captured.
   a_r7_capture: assert property (@(posedge clk) disable iff (!rst_n)
      (err_in && !sticky_q) |=> (sticky_q && addr_q == $past(addr_in)));

   // R7: the captured address holds until cleared.
   a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (sticky_q && !clr) |=> (sticky_q && $stable(addr_q)));

   // R8: a clear without a new error empties the flag.
   a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !err_in) |=> !sticky_q);

   // R8: a new error at the clear edge wins.
   a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && err_in) |=> (sticky_q && addr_q == $past(addr_in)));

endmodule

// File: rtl/cs_region_decoder.sv
module cs_region_decoder
   import cs_dec_pkg::*;
#(
   parameter int NUM_REGIONS = 8,
   parameter int ADDR_W      = 32,
   parameter int MATCH_W     = 8,
   localparam int IDX_W      = $clog2(NUM_REGIONS)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   req_valid,
   input  logic [ADDR_W-1:0]      req_addr,
   input  logic                   cfg_wr,
   input  logic [IDX_W-1:0]       cfg_idx,
   input  logic [MATCH_W-1:0]     cfg_base,
   input  logic [MATCH_W-1:0]     cfg_mask,
   input  logic                   cfg_enable,
   input  logic                   err_clr,
   output logic [NUM_REGIONS-1:0] cs_sel,
   output logic                   grant,
   output logic                   req_ack,
   output logic                   err_pulse,
   output logic                   err_sticky,
   output logic [ADDR_W-1:0]      err_addr
);

   // Elaboration-time parameter checks.
   if (NUM_REGIONS < 2) begin : g_bad_regions
      $error("cs_region_decoder: NUM_REGIONS must be at least 2");
   end
   if (MATCH_W < 1 || MATCH_W > ADDR_W) begin : g_bad_match_w
      $error("cs_region_decoder: MATCH_W must be within 1..ADDR_W");
   end

   logic [NUM_REGIONS-1:0][MATCH_W-1:0] base_q, mask_q;
   logic [NUM_REGIONS-1:0]              en_q;
   logic [NUM_REGIONS-1:0]              hits;
   logic [MATCH_W-1:0]                  tag;
   logic                                no_hit, multi_hit, err_now;
   outcome_e                            outc_d, outc_q;
   logic [NUM_REGIONS-1:0]              sel_q;

   cs_cfg_bank #(.NUM_REGIONS(NUM_REGIONS), .MATCH_W(MATCH_W)) u_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (cfg_wr),
      .wr_idx    (cfg_idx),
      .wr_base   (cfg_base),
      .wr_mask   (cfg_mask),
      .wr_enable (cfg_enable),
      .base_q    (base_q),
      .mask_q    (mask_q),
      .en_q      (en_q)
   );

   assign tag = req_addr[ADDR_W-1 -: MATCH_W];

   for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_match
      cs_region_match #(.MATCH_W(MATCH_W)) u_match (
         .tag    (tag),
         .base   (base_q[r]),
         .mask   (mask_q[r]),
         .enable (en_q[r]),
         .hit    (hits[r])
      );
   end

   // Two or more bits set <=> clearing the lowest set bit leaves something.
   assign no_hit    = (hits == '0);
   assign multi_hit = ((hits & (hits - NUM_REGIONS'(1))) != '0);
   assign err_now   = req_valid && (no_hit || multi_hit);

   always_comb begin
      if (!req_valid)     outc_d = OUTC_IDLE;
      else if (no_hit)    outc_d = OUTC_MISS;
      else if (multi_hit) outc_d = OUTC_CLASH;
      else                outc_d = OUTC_GRANT;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         outc_q <= OUTC_IDLE;
         sel_q  <= '0;
      end else begin
         outc_q <= outc_d;
         sel_q  <= (outc_d == OUTC_GRANT) ? hits : '0;
      end
   end

   assign cs_sel    = sel_q;
   assign grant     = (outc_q == OUTC_GRANT);
   assign req_ack   = (outc_q != OUTC_IDLE);
   assign err_pulse = (outc_q == OUTC_MISS) || (outc_q == OUTC_CLASH);

   cs_err_track #(.ADDR_W(ADDR_W)) u_err (
      .clk      (clk),
      .rst_n    (rst_n),
      .err_in   (err_now),
      .addr_in  (req_addr),
      .clr      (err_clr),
      .sticky_q (err_sticky),
      .addr_q   (err_addr)
   );

   // R2: never more than one chip-select.
   a_r2_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(cs_sel));

   // R2: a grant always comes with a select.
   a_r2_grant_has_sel: assert property (@(posedge clk) disable iff (!rst_n)
      grant |-> (cs_sel != '0));

   // R3/R4: an error never drives a chip-select.
   a_r4_err_no_sel: assert property (@(posedge clk) disable iff (!rst_n)
      err_pulse |-> (cs_sel == '0 && !grant));

   // R5: every request is acknowledged next cycle.
   a_r5_ack_follows: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> req_ack);

   // R6: quiet outputs after an idle edge.
   a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (cs_sel == '0 && !grant && !req_ack && !err_pulse));

endmodule

// File: tb/sim_cs_region_decoder.sv
module sim_cs_region_decoder;

   localparam int NR = 8;
   localparam int AW = 8;
   localparam int MW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic          cfg_wr = 1'b0;
   logic [2:0]    cfg_idx = '0;
   logic [MW-1:0] cfg_base = '0;
   logic [MW-1:0] cfg_mask = '0;
   logic          cfg_enable = 1'b0;
   logic          err_clr = 1'b0;
   logic [NR-1:0] cs_sel;
   logic          grant, req_ack, err_pulse, err_sticky;
   logic [AW-1:0] err_addr;

   int total = 0;
   int bad = 0;

   // Bench's own picture of the configuration and sticky state.
   logic [MW-1:0] m_base [NR];
   logic [MW-1:0] m_mask [NR];
   logic          m_en   [NR];
   logic          m_stk;
   logic [AW-1:0] m_saddr;

   always #5 clk = ~clk;

   cs_region_decoder #(.NUM_REGIONS(NR), .ADDR_W(AW), .MATCH_W(MW)) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .cfg_wr(cfg_wr), .cfg_idx(cfg_idx), .cfg_base(cfg_base),
      .cfg_mask(cfg_mask), .cfg_enable(cfg_enable), .err_clr(err_clr),
      .cs_sel(cs_sel), .grant(grant), .req_ack(req_ack),
      .err_pulse(err_pulse), .err_sticky(err_sticky), .err_addr(err_addr)
   );

   task automatic chk(input string rq, input string what,
                      input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
      end
   endtask

   // Apply one cycle of inputs, then check every output against the model.
   task automatic step(input logic rq, input logic [AW-1:0] a,
                       input logic clr, input string tagname);
      int            cnt;
      logic [NR-1:0] hits;
      logic [NR-1:0] e_sel;
      logic          e_err, e_gnt;
      string         lbl;
      @(negedge clk);
      cfg_wr    = 1'b0;
      req_valid = rq;
      req_addr  = a;
      err_clr   = clr;
      hits = '0;
      cnt  = 0;
      for (int i = 0; i < NR; i++) begin
         // R10: masked compare of the top MW address bits.
         if (m_en[i] && (((a[AW-1 -: MW] ^ m_base[i]) & m_mask[i]) == '0)) begin
            hits[i] = 1'b1;
            cnt++;
         end
      end
      e_gnt = rq && (cnt == 1);
      e_err = rq && (cnt != 1);
      e_sel = e_gnt ? hits : '0;
      if (!rq)           lbl = "R6";
      else if (cnt == 0) lbl = "R3";
      else if (cnt > 1)  lbl = "R4";
      else               lbl = "R2";
      if (tagname != "") lbl = tagname;
      if (clr) m_stk = 1'b0;
      if (e_err && !m_stk) begin
         m_stk   = 1'b1;
         m_saddr = a;
      end
      @(posedge clk);
      #1;
      chk(lbl, "cs_sel", int'(cs_sel), int'(e_sel));
      chk(lbl, "grant", int'(grant), int'(e_gnt));
      chk(lbl, "err_pulse", int'(err_pulse), int'(e_err));
      chk(rq ? "R5" : "R6", "req_ack", int'(req_ack), int'(rq));
      chk(clr ? "R8" : "R7", "err_sticky", int'(err_sticky), int'(m_stk));
      if (m_stk) chk(clr ? "R8" : "R7", "err_addr", int'(err_addr), int'(m_saddr));
   endtask

   task automatic cfg(input int idx, input logic [MW-1:0] b,
                      input logic [MW-1:0] m, input logic e);
      @(negedge clk);
      req_valid  = 1'b0;
      err_clr    = 1'b0;
      cfg_wr     = 1'b1;
      cfg_idx    = 3'(idx);
      cfg_base   = b;
      cfg_mask   = m;
      cfg_enable = e;
      m_base[idx] = b;
      m_mask[idx] = m;
      m_en[idx]   = e;
      @(posedge clk);
   endtask

   initial begin
      for (int i = 0; i < NR; i++) begin
         m_base[i] = '0;
         m_mask[i] = '0;
         m_en[i]   = (i == 0);
      end
      m_stk   = 1'b0;
      m_saddr = '0;
      repeat (3) @(posedge clk);
      #1;
      // R1: outputs quiet while in reset.
      chk("R1", "cs_sel in reset", int'(cs_sel), 0);
      chk("R1", "grant in reset", int'(grant), 0);
      chk("R1", "err_sticky in reset", int'(err_sticky), 0);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: region 0 alone covers the whole space after reset.
      for (int a = 0; a < 256; a++) step(1'b1, 8'(a), 1'b0, "R1");
      step(1'b0, '0, 1'b0, "");

      // Map: r0 tag 0, r1 tag 1, r2 tags 2-3, r5 tag 3 (clashes with r2),
      // r3 tags 8-15 but disabled, r4 tags 4-7, r6/r7 off: tags 8-15 miss.
      cfg(0, 4'h0, 4'hF, 1'b1);
      cfg(1, 4'h1, 4'hF, 1'b1);
      cfg(2, 4'h2, 4'hE, 1'b1);
      cfg(3, 4'h8, 4'h8, 1'b0);
      cfg(4, 4'h4, 4'hC, 1'b1);
      cfg(5, 4'h3, 4'hF, 1'b1);

      // R2 R3 R4 R10: full sweep, back to back; sticky holds first miss (R7).
      for (int a = 0; a < 256; a++) step(1'b1, 8'(a), 1'b0, "");
      step(1'b0, '0, 1'b0, "R6");

      // R8: clear, then clear coinciding with a new error.
      step(1'b0, '0, 1'b1, "R8");
      step(1'b1, 8'h9A, 1'b0, "R3");
      step(1'b1, 8'h31, 1'b0, "R4");
      step(1'b1, 8'hC5, 1'b1, "R8");
      step(1'b1, 8'h10, 1'b1, "R8");

      // R9: enabling r3 takes effect on the very next request.
      cfg(3, 4'h8, 4'h8, 1'b1);
      step(1'b1, 8'h9A, 1'b0, "R9");
      // R9: disabling r5 removes the clash at tag 3.
      cfg(5, 4'h3, 4'hF, 1'b0);
      step(1'b1, 8'h3F, 1'b0, "R9");
      // R10: low address bits are ignored; mask 0 bits don't care.
      step(1'b1, 8'h47, 1'b0, "R10");
      step(1'b1, 8'h7F, 1'b0, "R10");
      step(1'b0, '0, 1'b0, "R6");

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule